// File: doc/BRIEF.md
# Dimension-Ordered Mesh Router Tile

This block sits at one tile of a two-dimensional mesh and moves single-flit messages between the tile's local agent and the two rings that pass through it. One ring runs along the tile's column (the Y ring). The other runs along its row (the X ring). Each ring is one-directional, so the router has one input and one output per ring, plus a local inject port and a local eject port. Every port uses a valid/ready handshake.

Routing is dimension ordered. A message rides the Y ring until it reaches its destination row. It then turns onto the X ring and rides it until it reaches its destination column, where it is ejected to the local agent.

Contention is settled only where traffic enters a ring: when the local agent injects, and when Y traffic turns onto X. A message already moving along a ring always goes first. Turning traffic and injected traffic take turns for the X ring. Each output has a small queue. A full queue holds the handshake back toward the source, so no message is ever lost.

Top module: `mesh_router_tile`

## Requirements
- R1: A message is PAYLOAD_W+6 bits wide. The destination row is in bits [PAYLOAD_W+5:PAYLOAD_W+3], the destination column is in bits [PAYLOAD_W+2:PAYLOAD_W], and the payload is in the low PAYLOAD_W bits. The tile's own position is given by tileRow and tileCol, which lie inside the ROWS x COLS mesh.
- R2: A message arriving on the Y input whose row differs from tileRow leaves unchanged on the Y output.
- R3: A message arriving on the Y input whose row equals tileRow and whose column differs from tileCol turns and leaves unchanged on the X output.
- R4: A message arriving on the X input whose column differs from tileCol leaves on the X output. If its column equals tileCol, it leaves on the eject output.
- R5: A locally injected message whose row differs from tileRow leaves on the Y output. One whose row matches but whose column differs leaves on the X output.
- R6: A message whose destination equals (tileRow, tileCol), arriving from any input including the local one, leaves only on the eject output and never on either ring output.
- R7: When a message on a ring input needs to continue on that same ring, it is accepted ahead of any injected or turning message that wants the same output.
- R8: When no through traffic is present on the X ring, turning and injected messages that compete for the X output alternate. After a grant to one of them, the other is preferred. After reset, turning traffic is preferred.
- R9: When several messages want the eject output in the same cycle, the X input is served first, then the Y input, then the local input.
- R10: No message is dropped or reordered per output. An output holds its valid and data stable until ready is asserted. Each output queue holds FIFO_DEPTH messages. An input whose target queue is full sees ready low.
- R11: After reset, all three outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tileRow | input | 3 | Row coordinate of this tile |
| tileCol | input | 3 | Column coordinate of this tile |
| yInValid | input | 1 | Y ring input valid |
| yInReady | output | 1 | Y ring input ready |
| yInData | input | PAYLOAD_W+6 | Y ring input message |
| xInValid | input | 1 | X ring input valid |
| xInReady | output | 1 | X ring input ready |
| xInData | input | PAYLOAD_W+6 | X ring input message |
| locInValid | input | 1 | Local inject valid |
| locInReady | output | 1 | Local inject ready |
| locInData | input | PAYLOAD_W+6 | Local inject message |
| yOutValid | output | 1 | Y ring output valid |
| yOutReady | input | 1 | Y ring output ready |
| yOutData | output | PAYLOAD_W+6 | Y ring output message |
| xOutValid | output | 1 | X ring output valid |
| xOutReady | input | 1 | X ring output ready |
| xOutData | output | PAYLOAD_W+6 | X ring output message |
| ejOutValid | output | 1 | Local eject valid |
| ejOutReady | input | 1 | Local eject ready |
| ejOutData | output | PAYLOAD_W+6 | Local eject message |

## Verification
The assertions assume three things about the inputs:
- tileRow and tileCol stay constant and lie inside the mesh.
- A message on the X input already carries this tile's row, as it would after dimension-ordered routing upstream.
- Every source holds valid and data until its handshake completes.

The stimulus stays within these limits. The tile is fixed at row 2, column 3. X-input messages are only ever built with row 2. Every driver keeps its message asserted until it sees ready at a quiet point between clock edges.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

  localparam int COORD_W = 3;
  localparam int HEAD_W  = 2 * COORD_W;

  localparam int NUM_OUT = 3;
  localparam int OUT_Y   = 0;
  localparam int OUT_X   = 1;
  localparam int OUT_EJ  = 2;

  typedef struct packed {
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] col;
  } coord_t;

  typedef enum logic [1:0] {
    Y_NONE,
    Y_THRU,
    Y_INJ
  } ySel_e;

  typedef enum logic [1:0] {
    X_NONE,
    X_THRU,
    X_TURN,
    X_INJ
  } xSel_e;

  typedef enum logic [1:0] {
    EJ_NONE,
    EJ_FROM_X,
    EJ_FROM_Y,
    EJ_FROM_LOC
  } ejSel_e;

  typedef struct packed {
    ySel_e  ySel;
    xSel_e  xSel;
    ejSel_e ejSel;
  } routeStrobes_t;

endpackage

// File: rtl/mesh_router_fifo.sv
module mesh_router_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  output logic             hasSpace,
  output logic             popValid,
  input  logic             popReady,
  output logic [WIDTH-1:0] popData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushDo;
  logic             popDo;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign hasSpace = (count != CNT_W'(DEPTH));
  assign popValid = (count != '0);
  assign popData  = slots[rdPtr];
  assign pushDo   = pushEn && hasSpace;
  assign popDo    = popValid && popReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushDo) wrPtr <= bump(wrPtr);
      if (popDo)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(pushDo) - CNT_W'(popDo);
    end
  end

  always_ff @(posedge clk) begin
    if (pushDo) slots[wrPtr] <= pushData;
  end

endmodule

// File: rtl/mesh_router_ctrl.sv
module mesh_router_ctrl
  import mesh_router_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [COORD_W-1:0]        tileRow,
  input  logic [COORD_W-1:0]        tileCol,
  input  logic                      yInValid,
  input  logic                      xInValid,
  input  logic                      locInValid,
  input  coord_t                    yInDest,
  input  coord_t                    xInDest,
  input  coord_t                    locInDest,
  input  logic [NUM_OUT-1:0]        outSpace,
  output routeStrobes_t             strobes,
  output logic                      yInReady,
  output logic                      xInReady,
  output logic                      locInReady
);

  logic yWantY, yWantX, yWantEj;
  logic xWantX, xWantEj;
  logic lWantY, lWantX, lWantEj;
  logic preferTurn;
  ySel_e  ySel;
  xSel_e  xSel;
  ejSel_e ejSel;

  always_comb begin
    yWantY  = yInValid && (yInDest.row != tileRow);
    yWantX  = yInValid && (yInDest.row == tileRow) && (yInDest.col != tileCol);
    yWantEj = yInValid && (yInDest.row == tileRow) && (yInDest.col == tileCol);
    xWantX  = xInValid && (xInDest.col != tileCol);
    xWantEj = xInValid && (xInDest.col == tileCol);
    lWantY  = locInValid && (locInDest.row != tileRow);
    lWantX  = locInValid && (locInDest.row == tileRow) && (locInDest.col != tileCol);
    lWantEj = locInValid && (locInDest.row == tileRow) && (locInDest.col == tileCol);
  end

  // Y ring output: through traffic first, then injection
  always_comb begin
    ySel = Y_NONE;
    if (outSpace[OUT_Y]) begin
      if (yWantY)      ySel = Y_THRU;
      else if (lWantY) ySel = Y_INJ;
    end
  end

  // X ring output: through traffic first, then turn/inject alternate
  always_comb begin
    xSel = X_NONE;
    if (outSpace[OUT_X]) begin
      if (xWantX)                          xSel = X_THRU;
      else if (yWantX && (!lWantX || preferTurn)) xSel = X_TURN;
      else if (lWantX)                     xSel = X_INJ;
    end
  end

  // Eject: X, then Y, then local
  always_comb begin
    ejSel = EJ_NONE;
    if (outSpace[OUT_EJ]) begin
      if (xWantEj)      ejSel = EJ_FROM_X;
      else if (yWantEj) ejSel = EJ_FROM_Y;
      else if (lWantEj) ejSel = EJ_FROM_LOC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preferTurn <= 1'b1;
    end else if (xSel == X_TURN) begin
      preferTurn <= 1'b0;
    end else if (xSel == X_INJ) begin
      preferTurn <= 1'b1;
    end
  end

  assign strobes    = '{ySel: ySel, xSel: xSel, ejSel: ejSel};
  assign yInReady   = (ySel == Y_THRU) || (xSel == X_TURN) || (ejSel == EJ_FROM_Y);
  assign xInReady   = (xSel == X_THRU) || (ejSel == EJ_FROM_X);
  assign locInReady = (ySel == Y_INJ) || (xSel == X_INJ) || (ejSel == EJ_FROM_LOC);

endmodule

// File: rtl/mesh_router_dp.sv
module mesh_router_dp
  import mesh_router_pkg::*;
#(
  parameter int MSG_W      = 22,
  parameter int FIFO_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  routeStrobes_t      strobes,
  input  logic [MSG_W-1:0]   yInData,
  input  logic [MSG_W-1:0]   xInData,
  input  logic [MSG_W-1:0]   locInData,
  output coord_t             yInDest,
  output coord_t             xInDest,
  output coord_t             locInDest,
  output logic [NUM_OUT-1:0] outSpace,
  output logic               yOutValid,
  input  logic               yOutReady,
  output logic [MSG_W-1:0]   yOutData,
  output logic               xOutValid,
  input  logic               xOutReady,
  output logic [MSG_W-1:0]   xOutData,
  output logic               ejOutValid,
  input  logic               ejOutReady,
  output logic [MSG_W-1:0]   ejOutData
);

  logic [NUM_OUT-1:0] pushVec;
  logic [NUM_OUT-1:0] popValidVec;
  logic [NUM_OUT-1:0] popReadyVec;
  logic [MSG_W-1:0]   pushDataArr [NUM_OUT];
  logic [MSG_W-1:0]   popDataArr  [NUM_OUT];

  assign yInDest   = coord_t'(yInData[MSG_W-1 -: HEAD_W]);
  assign xInDest   = coord_t'(xInData[MSG_W-1 -: HEAD_W]);
  assign locInDest = coord_t'(locInData[MSG_W-1 -: HEAD_W]);

  always_comb begin
    pushVec[OUT_Y]     = (strobes.ySel != Y_NONE);
    pushDataArr[OUT_Y] = (strobes.ySel == Y_INJ) ? locInData : yInData;

    pushVec[OUT_X] = (strobes.xSel != X_NONE);
    unique case (strobes.xSel)
      X_TURN:  pushDataArr[OUT_X] = yInData;
      X_INJ:   pushDataArr[OUT_X] = locInData;
      default: pushDataArr[OUT_X] = xInData;
    endcase

    pushVec[OUT_EJ] = (strobes.ejSel != EJ_NONE);
    unique case (strobes.ejSel)
      EJ_FROM_Y:   pushDataArr[OUT_EJ] = yInData;
      EJ_FROM_LOC: pushDataArr[OUT_EJ] = locInData;
      default:     pushDataArr[OUT_EJ] = xInData;
    endcase
  end

  assign popReadyVec[OUT_Y]  = yOutReady;
  assign popReadyVec[OUT_X]  = xOutReady;
  assign popReadyVec[OUT_EJ] = ejOutReady;

  for (genvar g = 0; g < NUM_OUT; g++) begin : gen_outq
    mesh_router_fifo #(
      .WIDTH (MSG_W),
      .DEPTH (FIFO_DEPTH)
    ) outq_i (
      .clk      (clk),
      .rstN     (rstN),
      .pushEn   (pushVec[g]),
      .pushData (pushDataArr[g]),
      .hasSpace (outSpace[g]),
      .popValid (popValidVec[g]),
      .popReady (popReadyVec[g]),
      .popData  (popDataArr[g])
    );
  end

  assign yOutValid  = popValidVec[OUT_Y];
  assign yOutData   = popDataArr[OUT_Y];
  assign xOutValid  = popValidVec[OUT_X];
  assign xOutData   = popDataArr[OUT_X];
  assign ejOutValid = popValidVec[OUT_EJ];
  assign ejOutData  = popDataArr[OUT_EJ];

endmodule

// File: rtl/mesh_router_tile.sv
module mesh_router_tile
  import mesh_router_pkg::*;
#(
  parameter int ROWS       = 6,
  parameter int COLS       = 6,
  parameter int PAYLOAD_W  = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2:0]                tileRow,
  input  logic [2:0]                tileCol,
  input  logic                      yInValid,
  output logic                      yInReady,
  input  logic [PAYLOAD_W+5:0]      yInData,
  input  logic                      xInValid,
  output logic                      xInReady,
  input  logic [PAYLOAD_W+5:0]      xInData,
  input  logic                      locInValid,
  output logic                      locInReady,
  input  logic [PAYLOAD_W+5:0]      locInData,
  output logic                      yOutValid,
  input  logic                      yOutReady,
  output logic [PAYLOAD_W+5:0]      yOutData,
  output logic                      xOutValid,
  input  logic                      xOutReady,
  output logic [PAYLOAD_W+5:0]      xOutData,
  output logic                      ejOutValid,
  input  logic                      ejOutReady,
  output logic [PAYLOAD_W+5:0]      ejOutData
);

  localparam int MSG_W = PAYLOAD_W + HEAD_W;

  routeStrobes_t      strobes;
  coord_t             yInDest;
  coord_t             xInDest;
  coord_t             locInDest;
  logic [NUM_OUT-1:0] outSpace;

  mesh_router_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tileRow    (tileRow),
    .tileCol    (tileCol),
    .yInValid   (yInValid),
    .xInValid   (xInValid),
    .locInValid (locInValid),
    .yInDest    (yInDest),
    .xInDest    (xInDest),
    .locInDest  (locInDest),
    .outSpace   (outSpace),
    .strobes    (strobes),
    .yInReady   (yInReady),
    .xInReady   (xInReady),
    .locInReady (locInReady)
  );

  mesh_router_dp #(
    .MSG_W      (MSG_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .yInData    (yInData),
    .xInData    (xInData),
    .locInData  (locInData),
    .yInDest    (yInDest),
    .xInDest    (xInDest),
    .locInDest  (locInDest),
    .outSpace   (outSpace),
    .yOutValid  (yOutValid),
    .yOutReady  (yOutReady),
    .yOutData   (yOutData),
    .xOutValid  (xOutValid),
    .xOutReady  (xOutReady),
    .xOutData   (xOutData),
    .ejOutValid (ejOutValid),
    .ejOutReady (ejOutReady),
    .ejOutData  (ejOutData)
  );

endmodule

// File: rtl/mesh_router_tile_chk.sv
module mesh_router_tile_chk #(
  parameter int ROWS      = 6,
  parameter int COLS      = 6,
  parameter int PAYLOAD_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           tileRow,
  input logic [2:0]           tileCol,
  input logic                 yInValid,
  input logic                 yInReady,
  input logic [5:0]           yInHead,
  input logic                 xInValid,
  input logic                 xInReady,
  input logic [5:0]           xInHead,
  input logic                 locInValid,
  input logic                 locInReady,
  input logic [5:0]           locInHead,
  input logic                 yOutValid,
  input logic                 yOutReady,
  input logic [PAYLOAD_W+5:0] yOutData,
  input logic                 xOutValid,
  input logic                 xOutReady,
  input logic [PAYLOAD_W+5:0] xOutData,
  input logic                 ejOutValid,
  input logic                 ejOutReady,
  input logic [PAYLOAD_W+5:0] ejOutData
);

  localparam int TOP = PAYLOAD_W + 5;

  assert_tile_in_mesh_R1: assert property (@(posedge clk) disable iff (!rstN)
    (32'(tileRow) < ROWS) && (32'(tileCol) < COLS));

  assert_y_out_row_R2: assert property (@(posedge clk) disable iff (!rstN)
    yOutValid |-> (yOutData[TOP -: 3] != tileRow));

  assert_x_out_dest_R3: assert property (@(posedge clk) disable iff (!rstN)
    xOutValid |-> (xOutData[TOP -: 3] == tileRow) && (xOutData[TOP-3 -: 3] != tileCol));

  assert_eject_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    ejOutValid |-> (ejOutData[TOP -: 3] == tileRow) && (ejOutData[TOP-3 -: 3] == tileCol));

  assert_y_inflight_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (yInValid && (yInHead[5:3] != tileRow) && !yInReady &&
     locInValid && (locInHead[5:3] != tileRow)) |-> !locInReady);

  assert_x_inflight_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xInValid && (xInHead[2:0] != tileCol) && !xInReady) |->
      !(yInReady && (yInHead[5:3] == tileRow) && (yInHead[2:0] != tileCol)));

  assert_eject_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xInValid && (xInHead[2:0] == tileCol) && yInValid &&
     (yInHead[5:3] == tileRow) && (yInHead[2:0] == tileCol) && yInReady) |-> xInReady);

  assert_y_out_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (yOutValid && !yOutReady) |=> (yOutValid && $stable(yOutData)));

  assert_x_out_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (xOutValid && !xOutReady) |=> (xOutValid && $stable(xOutData)));

  assert_ej_out_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ejOutValid && !ejOutReady) |=> (ejOutValid && $stable(ejOutData)));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rstN |=> !(yOutValid || xOutValid || ejOutValid));

endmodule

bind mesh_router_tile mesh_router_tile_chk #(
  .ROWS      (ROWS),
  .COLS      (COLS),
  .PAYLOAD_W (PAYLOAD_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .tileRow    (tileRow),
  .tileCol    (tileCol),
  .yInValid   (yInValid),
  .yInReady   (yInReady),
  .yInHead    (yInData[PAYLOAD_W+5 -: 6]),
  .xInValid   (xInValid),
  .xInReady   (xInReady),
  .xInHead    (xInData[PAYLOAD_W+5 -: 6]),
  .locInValid (locInValid),
  .locInReady (locInReady),
  .locInHead  (locInData[PAYLOAD_W+5 -: 6]),
  .yOutValid  (yOutValid),
  .yOutReady  (yOutReady),
  .yOutData   (yOutData),
  .xOutValid  (xOutValid),
  .xOutReady  (xOutReady),
  .xOutData   (xOutData),
  .ejOutValid (ejOutValid),
  .ejOutReady (ejOutReady),
  .ejOutData  (ejOutData)
);

// File: tb/mesh_router_tile_tb_top.sv
`timescale 1ns/1ps
module mesh_router_tile_tb_top;

  localparam int PW = 16;
  localparam int MW = PW + 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic [2:0]    tileRow, tileCol;
  logic          yInValid, yInReady, xInValid, xInReady, locInValid, locInReady;
  logic [MW-1:0] yInData, xInData, locInData;
  logic          yOutValid, yOutReady, xOutValid, xOutReady, ejOutValid, ejOutReady;
  logic [MW-1:0] yOutData, xOutData, ejOutData;

  mesh_router_tile #(.ROWS(6), .COLS(6), .PAYLOAD_W(PW), .FIFO_DEPTH(2)) dut_i (
    .clk(clk), .rstN(rstN), .tileRow(tileRow), .tileCol(tileCol),
    .yInValid(yInValid), .yInReady(yInReady), .yInData(yInData),
    .xInValid(xInValid), .xInReady(xInReady), .xInData(xInData),
    .locInValid(locInValid), .locInReady(locInReady), .locInData(locInData),
    .yOutValid(yOutValid), .yOutReady(yOutReady), .yOutData(yOutData),
    .xOutValid(xOutValid), .xOutReady(xOutReady), .xOutData(xOutData),
    .ejOutValid(ejOutValid), .ejOutReady(ejOutReady), .ejOutData(ejOutData)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [MW-1:0] qY[$], qX[$], qE[$];
  string         tY[$], tX[$], tE[$];
  logic [MW-1:0] expY, expX, expE;
  string         tagY, tagX, tagE;

  function automatic logic [MW-1:0] mk(input int r, input int c, input int p);
    return {3'(r), 3'(c), PW'(p)};
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [MW-1:0] act, input logic [MW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input string what,
                          input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic expY_push(input logic [MW-1:0] m, input string t);
    qY.push_back(m); tY.push_back(t);
  endtask
  task automatic expX_push(input logic [MW-1:0] m, input string t);
    qX.push_back(m); tX.push_back(t);
  endtask
  task automatic expE_push(input logic [MW-1:0] m, input string t);
    qE.push_back(m); tE.push_back(t);
  endtask

  task automatic sendY(input logic [MW-1:0] m);
    @(negedge clk); yInValid = 1'b1; yInData = m; #1;
    while (!yInReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; yInValid = 1'b0;
  endtask

  task automatic sendX(input logic [MW-1:0] m);
    @(negedge clk); xInValid = 1'b1; xInData = m; #1;
    while (!xInReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; xInValid = 1'b0;
  endtask

  task automatic sendL(input logic [MW-1:0] m);
    @(negedge clk); locInValid = 1'b1; locInData = m; #1;
    while (!locInReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; locInValid = 1'b0;
  endtask

  // Scoreboard monitors: compare at each accepted output transfer
  always @(negedge clk) begin
    #2;
    if (rstN && yOutValid && yOutReady) begin
      if (qY.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R6 unexpected Y output: actual=%h expected=none", yOutData);
      end else begin
        expY = qY.pop_front(); tagY = tY.pop_front();
        checkEq(tagY, "yOutData", yOutData, expY);
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rstN && xOutValid && xOutReady) begin
      if (qX.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R6 unexpected X output: actual=%h expected=none", xOutData);
      end else begin
        expX = qX.pop_front(); tagX = tX.pop_front();
        checkEq(tagX, "xOutData", xOutData, expX);
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rstN && ejOutValid && ejOutReady) begin
      if (qE.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R9 unexpected eject output: actual=%h expected=none", ejOutData);
      end else begin
        expE = qE.pop_front(); tagE = tE.pop_front();
        checkEq(tagE, "ejOutData", ejOutData, expE);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL R10 watchdog expired: actual=hung expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tileRow = 3'd2; tileCol = 3'd3;
    yInValid = 0; xInValid = 0; locInValid = 0;
    yInData = '0; xInData = '0; locInData = '0;
    yOutReady = 1; xOutReady = 1; ejOutReady = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    // R11: quiet outputs after reset
    checkBit("R11", "yOutValid", yOutValid, 1'b0);
    checkBit("R11", "xOutValid", xOutValid, 1'b0);
    checkBit("R11", "ejOutValid", ejOutValid, 1'b0);

    // R2: Y through traffic (R1 header layout)
    expY_push(mk(5, 1, 16'h1111), "R2");  sendY(mk(5, 1, 16'h1111));
    expY_push(mk(0, 3, 16'h1212), "R2");  sendY(mk(0, 3, 16'h1212));
    // R3: turn onto X
    expX_push(mk(2, 0, 16'h2020), "R3");  sendY(mk(2, 0, 16'h2020));
    expX_push(mk(2, 5, 16'h2525), "R3");  sendY(mk(2, 5, 16'h2525));
    // R6: Y input to this tile ejects
    expE_push(mk(2, 3, 16'h6001), "R6");  sendY(mk(2, 3, 16'h6001));
    // R4: X through and X eject
    expX_push(mk(2, 1, 16'h4141), "R4");  sendX(mk(2, 1, 16'h4141));
    expE_push(mk(2, 3, 16'h4343), "R4");  sendX(mk(2, 3, 16'h4343));
    // R5: local injection to either ring
    expY_push(mk(4, 3, 16'h5403), "R5");  sendL(mk(4, 3, 16'h5403));
    expX_push(mk(2, 0, 16'h5200), "R5");  sendL(mk(2, 0, 16'h5200));
    // R6: self-addressed local message only ejects
    expE_push(mk(2, 3, 16'h6002), "R6");  sendL(mk(2, 3, 16'h6002));
    repeat (4) @(negedge clk);

    // R7: Y through beats Y injection
    expY_push(mk(0, 0, 16'h7001), "R7");
    expY_push(mk(1, 4, 16'h7002), "R7");
    expY_push(mk(5, 3, 16'h7003), "R7");
    fork
      begin sendY(mk(0, 0, 16'h7001)); sendY(mk(1, 4, 16'h7002)); end
      sendL(mk(5, 3, 16'h7003));
    join
    repeat (4) @(negedge clk);

    // R7: X through beats X injection (ends with inject grant)
    expX_push(mk(2, 0, 16'h7101), "R7");
    expX_push(mk(2, 1, 16'h7102), "R7");
    expX_push(mk(2, 4, 16'h7103), "R7");
    expX_push(mk(2, 5, 16'h7104), "R7");
    fork
      begin sendX(mk(2, 0, 16'h7101)); sendX(mk(2, 1, 16'h7102)); sendX(mk(2, 4, 16'h7103)); end
      sendL(mk(2, 5, 16'h7104));
    join
    repeat (4) @(negedge clk);

    // R8: turn and inject alternate, turn first after an inject grant
    expX_push(mk(2, 0, 16'h8a00), "R8");
    expX_push(mk(2, 1, 16'h8b00), "R8");
    expX_push(mk(2, 4, 16'h8a01), "R8");
    expX_push(mk(2, 5, 16'h8b01), "R8");
    expX_push(mk(2, 0, 16'h8a02), "R8");
    expX_push(mk(2, 1, 16'h8b02), "R8");
    fork
      begin sendY(mk(2, 0, 16'h8a00)); sendY(mk(2, 4, 16'h8a01)); sendY(mk(2, 0, 16'h8a02)); end
      begin sendL(mk(2, 1, 16'h8b00)); sendL(mk(2, 5, 16'h8b01)); sendL(mk(2, 1, 16'h8b02)); end
    join
    repeat (4) @(negedge clk);

    // R9: eject order X, Y, local
    expE_push(mk(2, 3, 16'h9001), "R9");
    expE_push(mk(2, 3, 16'h9002), "R9");
    expE_push(mk(2, 3, 16'h9003), "R9");
    fork
      sendX(mk(2, 3, 16'h9001));
      sendY(mk(2, 3, 16'h9002));
      sendL(mk(2, 3, 16'h9003));
    join
    repeat (4) @(negedge clk);

    // R10: backpressure stalls without loss
    @(negedge clk); xOutReady = 1'b0;
    expX_push(mk(2, 0, 16'hA001), "R10");
    expX_push(mk(2, 1, 16'hA002), "R10");
    expX_push(mk(2, 5, 16'hA003), "R10");
    sendL(mk(2, 0, 16'hA001));
    sendL(mk(2, 1, 16'hA002));
    @(negedge clk); locInValid = 1'b1; locInData = mk(2, 5, 16'hA003); #1;
    checkBit("R10", "locInReady with X queue full", locInReady, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    checkBit("R10", "xOutValid held", xOutValid, 1'b1);
    checkEq("R10", "xOutData held", xOutData, mk(2, 0, 16'hA001));
    xOutReady = 1'b1;
    while (!locInReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; locInValid = 1'b0;
    repeat (8) @(negedge clk);

    checkBit("R10", "all expected messages delivered",
             (qY.size() + qX.size() + qE.size()) == 0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule